// File: doc/BRIEF.md
# Four-Camera De-Interlacing Tile Engine

The block accepts four camera streams, each delivering interlaced video as two fields per frame, and builds one full progressive frame per camera inside a double-buffered store. While one bank is being filled, the other bank is read out as a single progressive window twice as wide and twice as tall as one camera image. Cameras 0 and 1 share the upper half of the window and cameras 2 and 3 share the lower half. Each window scanline is one full row of the left camera followed by the same row of the right camera.

The two banks trade roles when all four cameras have finished a frame. The display therefore trails capture by exactly one frame. If the write side finishes a frame while the readout of the other bank is still in progress, the finished frame is thrown away and a drop counter advances. The next frame then overwrites the same bank. The output is a valid/ready pixel stream with a start-of-window marker and an end-of-line marker. It can be stalled at any point without losing its place in the tile sequence. Image width and height are parameters, so small images can be used for tests.

Top module: `quad_tile_deint`

## Requirements
- R1: During reset and on the first cycle after it, `out_valid` is 0 and `drop_count` is 0.
- R2: Within each camera, the k-th line of the field with `cam_field`=0 lands on frame row 2k, and the k-th line of the field with `cam_field`=1 lands on row 2k+1. Pixels within a line take columns 0 upward in arrival order, and `cam_eol` marks the last pixel of a line. Each frame sends field 0 first, then field 1.
- R3: Camera c uses bit c of `cam_valid`, `cam_field` and `cam_eol`, and bits [c*PIX_W +: PIX_W] of `cam_pix`. Window row r (0 ≤ r < IMG_H) is row r of camera 0 followed by row r of camera 1. Window row IMG_H+r is row r of camera 2 followed by row r of camera 3. Each window line has 2*IMG_W pixels and there are 2*IMG_H lines.
- R4: `out_sow` is high only with the first pixel of a window. `out_eol` is high only with the last pixel of each window line. Neither is high without `out_valid`.
- R5: No pixel is emitted before all four cameras have completed a frame. `out_valid` rises on the cycle after the completing input pixel is accepted, and it rises together with `out_sow`.
- R6: A frame written while a readout is in progress goes to the other bank and does not alter the pixels being read out.
- R7: A frame that completes while a readout is still unfinished is discarded, and `drop_count` rises by exactly one. The readout in progress continues undisturbed. The discarded frame never appears at the output.
- R8: While `out_valid` is high and `out_ready` is low, `out_pix`, `out_sow`, `out_eol` and `out_valid` hold their values.
- R9: After the last pixel of a window is accepted, `out_valid` goes low unless another frame completed in that same cycle.
- R10: The four cameras are paced independently. Their valid strobes need not coincide, and a frame completes when the slowest camera finishes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cam_valid | input | 4 | Per-camera pixel strobe |
| cam_pix | input | 4*PIX_W | Per-camera pixel values, camera c at [c*PIX_W +: PIX_W] |
| cam_field | input | 4 | Per-camera field parity of the current pixel |
| cam_eol | input | 4 | Per-camera last-pixel-of-line marker |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_pix | output | PIX_W | Output pixel value |
| out_sow | output | 1 | First pixel of a window |
| out_eol | output | 1 | Last pixel of a window line |
| drop_count | output | CNT_W | Number of discarded frames, wrapping |

## Verification
The bench targets the field-to-row mapping and the tile order. A design that swapped the field parity, or that read the cameras in the wrong half, would show pixels from the wrong row or quadrant. It also targets a readout held off completely while a second frame arrives. A design that swapped banks there would later emit the dropped frame, or would corrupt the frame it was showing. Random backpressure exposes a design that advanced its position without a handshake. A slow frame written alongside a fast readout checks that writes never reach the bank being read. A design that lost cross-camera completion would start the readout early, while the camera streams are deliberately skewed.

// File: rtl/qtd_pkg.sv
// Shared constants for the four-camera de-interlace tiler.
// Assumes a fixed 2x2 mosaic, so the camera count is not a parameter.
package qtd_pkg;
    localparam int NCAM  = 4;
    localparam int CAM_W = 2;

    // Mosaic position of a camera: {lower half, right half}
    typedef logic [CAM_W-1:0] cam_idx_t;
endpackage

// File: rtl/qtd_field_writer.sv
// Per-camera write address generator.
// Turns a field/line-marked pixel stream into frame addresses: rows are
// interleaved by field parity. Assumes field 0 precedes field 1 and that each
// line is closed by an end-of-line marker on its last pixel.
module qtd_field_writer #(
    parameter int IMG_W = 8,
    parameter int IMG_H = 4,
    parameter int AW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_field,
    input  logic          in_eol,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic          frame_done
);
    localparam int HALF = IMG_H / 2;
    localparam int LW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int CW   = (IMG_W > 1) ? $clog2(IMG_W) : 1;

    logic [CW-1:0] col_q;
    logic [LW-1:0] line_q;
    logic          last_line;

    assign last_line  = (line_q == LW'(HALF - 1));
    assign wr_en      = in_valid;
    assign wr_addr    = AW'((2 * int'(line_q) + int'(in_field)) * IMG_W + int'(col_q));
    assign frame_done = in_valid && in_eol && in_field && last_line;

    // Advance column within a line, line within a field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q  <= '0;
            line_q <= '0;
        end else if (in_valid) begin
            if (in_eol) begin
                col_q  <= '0;
                line_q <= last_line ? '0 : line_q + 1'b1;
            end else begin
                col_q  <= col_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/qtd_bank_ram.sv
// Two-bank pixel store for one camera.
// One synchronous write port and one asynchronous read port. Assumes the
// caller keeps the read and write banks apart.
module qtd_bank_ram #(
    parameter int PIX_W = 8,
    parameter int DEPTH = 32,
    parameter int AW    = 5
) (
    input  logic             clk,
    input  logic             we,
    input  logic             wbank,
    input  logic [AW-1:0]    waddr,
    input  logic [PIX_W-1:0] wdata,
    input  logic             rbank,
    input  logic [AW-1:0]    raddr,
    output logic [PIX_W-1:0] rdata
);
    localparam int MA = $clog2(2 * DEPTH);

    logic [PIX_W-1:0] mem [2*DEPTH];
    logic [MA-1:0]    widx;
    logic [MA-1:0]    ridx;

    assign widx  = MA'(int'(wbank) * DEPTH + int'(waddr));
    assign ridx  = MA'(int'(rbank) * DEPTH + int'(raddr));
    assign rdata = mem[ridx];

    // Store an incoming pixel into the write bank
    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
    end
endmodule

// File: rtl/qtd_tile_reader.sv
// Mosaic readout sequencer.
// Walks a window of 2*IMG_W x 2*IMG_H pixels and maps each position to a
// camera and a frame address. It advances only on a valid/ready handshake.
// A start pulse restarts it at the window origin.
module qtd_tile_reader
    import qtd_pkg::*;
#(
    parameter int IMG_W = 8,
    parameter int IMG_H = 4,
    parameter int AW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          ready,
    output logic          valid,
    output cam_idx_t      cam,
    output logic [AW-1:0] raddr,
    output logic          sow,
    output logic          eol,
    output logic          last_xfer
);
    localparam int XW = $clog2(2 * IMG_W);
    localparam int RW = $clog2(2 * IMG_H);

    logic          busy_q;
    logic [XW-1:0] x_q;
    logic [RW-1:0] r_q;
    logic          lower, right;
    logic [XW-1:0] col;
    logic [RW-1:0] row;

    assign lower     = (r_q >= RW'(IMG_H));
    assign right     = (x_q >= XW'(IMG_W));
    assign row       = lower ? r_q - RW'(IMG_H) : r_q;
    assign col       = right ? x_q - XW'(IMG_W) : x_q;
    assign cam       = {lower, right};
    assign raddr     = AW'(int'(row) * IMG_W + int'(col));
    assign valid     = busy_q;
    assign sow       = busy_q && (x_q == '0) && (r_q == '0);
    assign eol       = busy_q && (x_q == XW'(2 * IMG_W - 1));
    assign last_xfer = eol && ready && (r_q == RW'(2 * IMG_H - 1));

    // Step through window columns and lines on each accepted pixel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            x_q    <= '0;
            r_q    <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            x_q    <= '0;
            r_q    <= '0;
        end else if (busy_q && ready) begin
            if (eol) begin
                x_q <= '0;
                if (r_q == RW'(2 * IMG_H - 1)) begin
                    busy_q <= 1'b0;
                    r_q    <= '0;
                end else begin
                    r_q <= r_q + 1'b1;
                end
            end else begin
                x_q <= x_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/quad_tile_deint.sv
// Four-camera de-interlace tiling engine.
// Collects one interlaced frame per camera into the write bank. Once all four
// are complete, it swaps banks and streams the finished bank as a 2x2 mosaic.
// A frame that completes during an unfinished readout is dropped and counted.
// Assumes no camera starts its next frame before all four have finished the
// current one.
module quad_tile_deint
    import qtd_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int IMG_W = 8,
    parameter int IMG_H = 4,
    parameter int CNT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCAM-1:0]       cam_valid,
    input  logic [NCAM*PIX_W-1:0] cam_pix,
    input  logic [NCAM-1:0]       cam_field,
    input  logic [NCAM-1:0]       cam_eol,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [PIX_W-1:0]      out_pix,
    output logic                  out_sow,
    output logic                  out_eol,
    output logic [CNT_W-1:0]      drop_count
);
    localparam int DEPTH = IMG_W * IMG_H;
    localparam int AW    = $clog2(DEPTH);

    logic             wr_bank_q;
    logic [NCAM-1:0]  done_q;
    logic [NCAM-1:0]  fdone;
    logic [PIX_W-1:0] rd_pix [NCAM];
    logic [AW-1:0]    rd_addr;
    cam_idx_t         rd_cam;
    logic             last_xfer;
    logic             all_done, hold, swap;

    for (genvar c = 0; c < NCAM; c++) begin : g_cam
        logic          we;
        logic [AW-1:0] waddr;

        qtd_field_writer #(.IMG_W(IMG_W), .IMG_H(IMG_H), .AW(AW)) u_wr (
            .clk        (clk),
            .rst_n      (rst_n),
            .in_valid   (cam_valid[c]),
            .in_field   (cam_field[c]),
            .in_eol     (cam_eol[c]),
            .wr_en      (we),
            .wr_addr    (waddr),
            .frame_done (fdone[c])
        );

        qtd_bank_ram #(.PIX_W(PIX_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
            .clk   (clk),
            .we    (we),
            .wbank (wr_bank_q),
            .waddr (waddr),
            .wdata (cam_pix[c*PIX_W +: PIX_W]),
            .rbank (~wr_bank_q),
            .raddr (rd_addr),
            .rdata (rd_pix[c])
        );
    end

    qtd_tile_reader #(.IMG_W(IMG_W), .IMG_H(IMG_H), .AW(AW)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (swap),
        .ready     (out_ready),
        .valid     (out_valid),
        .cam       (rd_cam),
        .raddr     (rd_addr),
        .sow       (out_sow),
        .eol       (out_eol),
        .last_xfer (last_xfer)
    );

    assign out_pix  = rd_pix[rd_cam];
    assign all_done = &(done_q | fdone);
    assign hold     = out_valid && !last_xfer;
    assign swap     = all_done && !hold;

    // Track per-camera completion, swap banks or count a drop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q     <= '0;
            wr_bank_q  <= 1'b0;
            drop_count <= '0;
        end else begin
            done_q <= all_done ? '0 : (done_q | fdone);
            if (swap)
                wr_bank_q <= ~wr_bank_q;
            if (all_done && hold)
                drop_count <= drop_count + 1'b1;
        end
    end
endmodule

// File: rtl/qtd_checker.sv
// Temporal checks on the tiler's output port, attached by bind.
module qtd_checker #(
    parameter int PIX_W = 8,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_valid,
    input logic             out_ready,
    input logic [PIX_W-1:0] out_pix,
    input logic             out_sow,
    input logic             out_eol,
    input logic [CNT_W-1:0] drop_count
);
    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
        (out_valid && $stable(out_pix) && $stable(out_sow) && $stable(out_eol)));

    // R7
    drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count != $past(drop_count)) |-> (drop_count == $past(drop_count) + 1'b1));

    // R7
    drop_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count != $past(drop_count)) |-> $past(out_valid));

    // R4
    marker_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sow || out_eol) |-> out_valid);

    // R5
    window_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_sow);

    // R9
    window_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> $past(out_eol && out_ready));
endmodule

bind quad_tile_deint qtd_checker #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_pix    (out_pix),
    .out_sow    (out_sow),
    .out_eol    (out_eol),
    .drop_count (drop_count)
);

// File: tb/quad_tile_deint_tb.sv
`timescale 1ns/1ps
module quad_tile_deint_tb;
    localparam int PW = 8;
    localparam int W  = 8;
    localparam int H  = 4;
    localparam int CW = 8;
    localparam int N  = W * H;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [3:0]     cam_valid = '0;
    logic [4*PW-1:0] cam_pix = '0;
    logic [3:0]     cam_field = '0;
    logic [3:0]     cam_eol = '0;
    logic           out_valid;
    logic           out_ready = 1'b0;
    logic [PW-1:0]  out_pix;
    logic           out_sow;
    logic           out_eol;
    logic [CW-1:0]  drop_count;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    quad_tile_deint #(.PIX_W(PW), .IMG_W(W), .IMG_H(H), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cam_valid(cam_valid), .cam_pix(cam_pix),
        .cam_field(cam_field), .cam_eol(cam_eol), .out_valid(out_valid),
        .out_ready(out_ready), .out_pix(out_pix), .out_sow(out_sow),
        .out_eol(out_eol), .drop_count(drop_count)
    );

    // Reference pixel value of frame fr, camera cam, frame row/col
    function automatic logic [PW-1:0] pix_of(int fr, int cam, int row, int col);
        return PW'((fr * 53 + cam * 101 + row * 17 + col * 3 + 11) % 256);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Drive one frame on all cameras, each paced independently (R10, R2)
    task automatic send_frame(int fr, int pct, output int early);
        int idx[4] = '{0, 0, 0, 0};
        early = 0;
        while (idx[0] < N || idx[1] < N || idx[2] < N || idx[3] < N) begin
            @(negedge clk);
            if (out_valid) early++;
            for (int c = 0; c < 4; c++) begin
                if (idx[c] < N && ($urandom % 100) < pct) begin
                    int f   = idx[c] / (N / 2);
                    int ln  = (idx[c] % (N / 2)) / W;
                    int col = idx[c] % W;
                    cam_valid[c] = 1'b1;
                    cam_field[c] = f[0];
                    cam_eol[c]   = (col == W - 1);
                    cam_pix[c*PW +: PW] = pix_of(fr, c, 2 * ln + f, col);
                    idx[c]++;
                end else begin
                    cam_valid[c] = 1'b0;
                    cam_eol[c]   = 1'b0;
                end
            end
        end
        @(negedge clk);
        cam_valid = '0;
        cam_eol   = '0;
    endtask

    // Accept a whole window and compare every pixel and marker (R3, R4, R8)
    task automatic collect(int fr, int pct);
        int k = 0;
        while (k < 4 * N) begin
            @(negedge clk);
            out_ready = (($urandom % 100) < pct);
            #1;
            if (out_valid && out_ready) begin
                int r   = k / (2 * W);
                int x   = k % (2 * W);
                int cam = (r >= H ? 2 : 0) + (x >= W ? 1 : 0);
                int exp = {(k == 0), (x == 2 * W - 1),
                           pix_of(fr, cam, r % H, x % W)};
                int act = {out_sow, out_eol, out_pix};
                chk(act == exp, "R3/R4 tile pixel {sow,eol,pix}", act, exp);
                k++;
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
        #1;
        chk(out_valid == 1'b0, "R9 idle after window", int'(out_valid), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int early;
        void'($urandom(20240611));
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
        chk(drop_count == '0, "R1 reset drop", int'(drop_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
        chk(drop_count == '0, "R1 drop after reset", int'(drop_count), 0);

        // Frame 0: nothing emitted before completion, then window starts (R5)
        send_frame(0, 70, early);
        chk(early == 0, "R5 no output before frame", early, 0);
        #1;
        chk(out_valid == 1'b1, "R5 readout started", int'(out_valid), 1);
        chk(out_sow == 1'b1, "R5 starts with sow", int'(out_sow), 1);

        // Frame 1 completes while readout is held off: dropped (R7)
        send_frame(1, 100, early);
        #1;
        chk(drop_count == CW'(1), "R7 drop counted", int'(drop_count), 1);
        chk(out_valid && out_sow, "R8 position held under stall",
            int'({out_valid, out_sow}), 3);
        chk(out_pix == pix_of(0, 0, 0, 0), "R7 readout undisturbed",
            int'(out_pix), int'(pix_of(0, 0, 0, 0)));
        collect(0, 60);

        // Frame 2 must appear, never the dropped frame 1 (R7)
        send_frame(2, 90, early);
        collect(2, 70);

        // Frame 4 written slowly into the other bank during readout of 3 (R6)
        send_frame(3, 100, early);
        fork
            collect(3, 100);
            send_frame(4, 6, early);
        join
        chk(drop_count == CW'(1), "R6 no drop on overlap", int'(drop_count), 1);
        #1;
        chk(out_valid == 1'b1, "R6 next window ready", int'(out_valid), 1);
        collect(4, 50);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule